// File: doc/BRIEF.md
# Read-once secret word store

This block holds a device secret, split into a small number of fixed-width words, and hands each word out exactly once per reset. A simple read port offers chip select, an 8-bit address and a read-data word. The secret words sit in a window of eight consecutive addresses. The initial secret comes in as a parameter and is held in discrete registers. Nothing can write to it.

Each word has a sticky consumed flag. The flag is set on the clock edge that completes a granted read, and after that the word reads back as zero until the next reset. A mode input marks when the system runs application code rather than firmware. While it is high, every read returns zero and no flag changes. Read data is combinational. It shows the selected word in the same cycle as the request, together with a one-cycle ready pulse.

Reset is synchronous and active-low. It clears every consumed flag but leaves the secret values as they are.

Top module: `onceread_store`

## Requirements
- R1: In the first cycle after reset, with chip select low, the read data is 32'h0 and ready is 0.
- R2: While chip select is low, the read data is 32'h0 and ready is 0, whatever the address and mode.
- R3: With chip select high, the mode input low and address 0x10+k (k = 0..7), if word k has not been consumed the read data equals secret word k in the same cycle and ready is 1. Word k is bits [32k+31:32k] of the secret parameter.
- R4: A word becomes consumed on the rising clock edge that ends a granted read of it. From then on, any read of that word returns 32'h0 with ready 0, and this includes chip select held high on the same address in the next cycle.
- R5: Consuming one word does not affect the others. Words can be read in any order, and each still returns its own value on its first read.
- R6: While the mode input is high, every read returns 32'h0 with ready 0 and consumes no word. A later read of the same word with the mode input low still returns its value.
- R7: Addresses outside 0x10..0x17 return 32'h0 with ready 0 and consume no word.
- R8: Reset clears every consumed flag and leaves the secret unchanged, so after reset each word again returns its original value once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous active-low reset; clears the consumed flags |
| csIn | input | 1 | Chip select for a read |
| addrIn | input | 8 | Read address; secret words at 0x10..0x17 |
| appModeIn | input | 1 | High while application code runs; blocks all reads |
| rdDataOut | output | 32 | Combinational read data; zero unless a read is granted |
| readyOut | output | 1 | High in the cycle a secret word is delivered |

## Verification
Two things can fall in the same cycle: delivering a word and consuming it. The consuming edge closes the very cycle in which the word is shown on the output. The bench provokes this by holding chip select on one address for three cycles in a row. The first cycle must show the word with ready high, and the following cycles must show zero with ready low. The mode gate and the address decode are swept exhaustively before any grant, and a later fresh read then shows that neither consumed anything.

// File: rtl/onceread_pkg.sv
package onceread_pkg;

  // number of secret words held by the store
  parameter int unsigned VAULT_WORDS = 8;

  // strobes from control to datapath
  typedef struct packed {
    logic                   deliver; // a fresh word is handed out this cycle
    logic [VAULT_WORDS-1:0] pick;    // one-hot select of the fresh word
  } vaultStb_t;

endpackage

// File: rtl/onceread_ctrl.sv
module onceread_ctrl
  import onceread_pkg::*;
#(
  parameter int unsigned     ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csIn,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              appModeIn,
  output vaultStb_t         stbOut,
  output logic              readyOut
);

  localparam logic [ADDR_W:0] SPAN = (ADDR_W+1)'(VAULT_WORDS);

  logic [ADDR_W-1:0]      offset;
  logic                   inWindow;
  logic                   requestOk;
  logic [VAULT_WORDS-1:0] decodeHot;
  logic [VAULT_WORDS-1:0] reqPick;
  logic [VAULT_WORDS-1:0] freshPick;
  logic [VAULT_WORDS-1:0] consumedQ;
  logic [VAULT_WORDS-1:0] consumedD;

  // an address below the base wraps to a large offset and falls outside
  assign offset    = addrIn - BASE_ADDR;
  assign inWindow  = ({1'b0, offset} < SPAN);
  assign requestOk = csIn && inWindow && !appModeIn;

  for (genvar g = 0; g < VAULT_WORDS; g++) begin : gDecode
    assign decodeHot[g] = inWindow && (offset == ADDR_W'(g));
  end

  always_comb begin
    reqPick   = requestOk ? decodeHot : '0;
    freshPick = reqPick & ~consumedQ;
    consumedD = consumedQ | reqPick;
  end

  always_ff @(posedge clk) begin
    if (!rstN) consumedQ <= '0;
    else       consumedQ <= consumedD;
  end

  assign stbOut.deliver = |freshPick;
  assign stbOut.pick    = freshPick;
  assign readyOut       = |freshPick;

  // R4
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((consumedQ & $past(consumedQ)) == $past(consumedQ)));

  // R4
  consume_after_deliver_chk: assert property (@(posedge clk) disable iff (!rstN)
    stbOut.deliver |=> ((consumedQ & $past(stbOut.pick)) == $past(stbOut.pick)));

  // R5
  single_consume_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(consumedQ ^ $past(consumedQ)) <= 1));

  // R6
  app_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    appModeIn |=> $stable(consumedQ));

  // R7
  window_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inWindow |=> $stable(consumedQ));

endmodule

// File: rtl/onceread_dpath.sv
module onceread_dpath
  import onceread_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter logic [VAULT_WORDS*WORD_W-1:0] SECRET_INIT = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  vaultStb_t         stbIn,
  output logic [WORD_W-1:0] rdDataOut
);

  localparam int unsigned IMG_W = VAULT_WORDS * WORD_W;

  logic [IMG_W-1:0]  secretQ;
  logic [WORD_W-1:0] masked [VAULT_WORDS];

  // preset image; reloading the same value on reset leaves it unchanged
  always_ff @(posedge clk) begin
    if (!rstN) secretQ <= SECRET_INIT;
    else       secretQ <= secretQ;
  end

  for (genvar g = 0; g < VAULT_WORDS; g++) begin : gMask
    assign masked[g] = stbIn.pick[g] ? secretQ[g*WORD_W +: WORD_W] : '0;
  end

  always_comb begin
    rdDataOut = '0;
    for (int i = 0; i < VAULT_WORDS; i++) rdDataOut = rdDataOut | masked[i];
  end

  // R2
  zero_unless_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdDataOut != '0) |-> stbIn.deliver);

  // R5
  pick_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stbIn.pick));

  // R8
  secret_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> $stable(secretQ));

endmodule

// File: rtl/onceread_store.sv
module onceread_store
  import onceread_pkg::*;
#(
  parameter int unsigned     WORD_W    = 32,
  parameter int unsigned     ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h10,
  parameter logic [VAULT_WORDS*WORD_W-1:0] SECRET_INIT = {
    32'h7d3c_19a4, 32'h2be0_5f61, 32'hc914_8e07, 32'h56aa_f0d3,
    32'h0e87_42bc, 32'hb1f5_6a28, 32'h4c62_d795, 32'h93d8_0b1e}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csIn,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              appModeIn,
  output logic [WORD_W-1:0] rdDataOut,
  output logic              readyOut
);

  vaultStb_t stb;

  onceread_ctrl #(
    .ADDR_W   (ADDR_W),
    .BASE_ADDR(BASE_ADDR)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .csIn     (csIn),
    .addrIn   (addrIn),
    .appModeIn(appModeIn),
    .stbOut   (stb),
    .readyOut (readyOut)
  );

  onceread_dpath #(
    .WORD_W     (WORD_W),
    .SECRET_INIT(SECRET_INIT)
  ) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .stbIn    (stb),
    .rdDataOut(rdDataOut)
  );

endmodule

// File: tb/sim_onceread_store.sv
`timescale 1ns/1ps
module sim_onceread_store;

  function automatic logic [31:0] expWord(input int k);
    return (32'h9e37_79b9 * 32'(k + 1)) ^ 32'h0f1e_2d3c;
  endfunction

  function automatic logic [255:0] buildImage();
    logic [255:0] img;
    img = '0;
    for (int k = 0; k < 8; k++) img[k*32 +: 32] = expWord(k);
    return img;
  endfunction

  localparam logic [255:0] IMAGE = buildImage();

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csIn = 1'b0;
  logic [7:0]  addrIn = 8'h00;
  logic        appModeIn = 1'b0;
  logic [31:0] rdDataOut;
  logic        readyOut;
  int          total = 0;
  int          bad = 0;

  always #2 clk = ~clk;

  onceread_store #(.SECRET_INIT(IMAGE)) u0 (
    .clk(clk), .rstN(rstN), .csIn(csIn), .addrIn(addrIn),
    .appModeIn(appModeIn), .rdDataOut(rdDataOut), .readyOut(readyOut)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // drive at the falling edge, sample 1 ns later, before the rising edge
  task automatic probe(input logic cs, input logic [7:0] a, input logic m,
                       input logic [31:0] expD, input logic expR, input string tag);
    @(negedge clk);
    csIn = cs; addrIn = a; appModeIn = m;
    #1;
    chk({tag, " data"}, rdDataOut, expD);
    chk({tag, " ready"}, {31'b0, readyOut}, {31'b0, expR});
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; csIn = 1'b0; appModeIn = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    doReset();
    #1;
    // R1 reset state
    chk("R1 idle data", rdDataOut, 32'h0);
    chk("R1 idle ready", {31'b0, readyOut}, 32'h0);

    // R2 chip select low on every secret address, both modes
    for (int k = 0; k < 8; k++) begin
      probe(1'b0, 8'(8'h10 + k), 1'b0, 32'h0, 1'b0, "R2 cs low fw");
      probe(1'b0, 8'(8'h10 + k), 1'b1, 32'h0, 1'b0, "R2 cs low app");
    end

    // R6 application mode blocks every secret word
    for (int k = 0; k < 8; k++)
      probe(1'b1, 8'(8'h10 + k), 1'b1, 32'h0, 1'b0, "R6 app mode");

    // R7 exhaustive sweep outside the window
    for (int a = 0; a < 256; a++)
      if (a < 8'h10 || a > 8'h17)
        probe(1'b1, 8'(a), 1'b0, 32'h0, 1'b0, "R7 outside window");

    // R3 R5 R6 R7 permuted first reads, each followed by a re-read (R4)
    for (int n = 0; n < 8; n++) begin
      int k;
      k = (n * 5 + 3) % 8;
      probe(1'b1, 8'(8'h10 + k), 1'b0, expWord(k), 1'b1, "R3 R5 first read");
      probe(1'b1, 8'(8'h10 + k), 1'b0, 32'h0, 1'b0, "R4 held re-read");
      probe(1'b0, 8'h00, 1'b0, 32'h0, 1'b0, "R2 gap");
    end

    // R4 every word now reads zero
    for (int k = 0; k < 8; k++)
      probe(1'b1, 8'(8'h10 + k), 1'b0, 32'h0, 1'b0, "R4 consumed");

    // R8 reset restores access with unchanged values
    doReset();
    probe(1'b1, 8'h12, 1'b0, expWord(2), 1'b1, "R8 R4 held cycle 1");
    probe(1'b1, 8'h12, 1'b0, 32'h0, 1'b0, "R4 held cycle 2");
    probe(1'b1, 8'h12, 1'b0, 32'h0, 1'b0, "R4 held cycle 3");
    // R6 mode rising while a fresh word is requested: no consume
    probe(1'b1, 8'h15, 1'b1, 32'h0, 1'b0, "R6 gate on fresh word");
    for (int k = 0; k < 8; k++)
      if (k != 2)
        probe(1'b1, 8'(8'h10 + k), 1'b0, expWord(k), 1'b1, "R8 R5 after reset");
    probe(1'b0, 8'h00, 1'b0, 32'h0, 1'b0, "R2 final idle");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule